// File: doc/BRIEF.md
# Sigma-Delta Converter Host Reader

This block is the host-side controller for a read-only serial converter that exposes only a serial clock input and one shared data/ready output. The block drives the converter's active-low power-down/reset pin. It then waits out the converter's internal clock start-up and watches the shared line for a ready indication. When that indication arrives, it clocks a 24-bit frame in, most significant bit first. The first 16 bits are the conversion result and the last 8 are status bits. The block presents both on a parallel bus with a one-cycle valid strobe.

The converter's digital filter needs a settling interval after every reset, and results delivered inside that interval are unreliable. The block therefore times the settling interval itself and tags every result that completes early. If no ready indication arrives within a timeout, the block raises an error flag and runs the whole reset, start-up and settling sequence again. All time intervals are parameters counted in system-clock cycles. The serial clock is derived from the system clock and idles high.

Top module: `sdadc_host_reader`

## Requirements
- R1: After `rst_n` is released, `adc_pdrst_n_o` is low for exactly `RESET_CYC` cycles and then rises. During reset, `adc_sclk_o` is 1, `result_valid_o` is 0, `timeout_err_o` is 0 and `result_o` is 0.
- R2: The data/ready line is ignored while `adc_pdrst_n_o` is low and for `PWRUP_CYC` cycles after it rises. In that time `adc_sclk_o` stays 1 and no result is produced, even if the line toggles.
- R3: Once the start-up window has ended, a falling transition of the synchronised data/ready line starts a frame. The frame consists of exactly 24 serial-clock periods, each low for `SCLK_HALF` cycles and then high for `SCLK_HALF` cycles. Between frames the serial clock stays high.
- R4: Each bit is sampled at the end of the high phase that follows its falling edge. The first bit received is the result MSB. Bits 1 to 16 form `result_o[15:0]` and bits 17 to 24 form `status_o[7:0]`, MSB first.
- R5: `result_o`, `status_o` and `unsettled_o` change only in the cycle in which `result_valid_o` is 1. `result_valid_o` is a single-cycle pulse.
- R6: `unsettled_o` is 1 for a result whose last bit is sampled fewer than `SETTLE_CYC` cycles after `adc_pdrst_n_o` last rose, and 0 otherwise.
- R7: If no ready indication arrives within `TIMEOUT_CYC` cycles of waiting, `timeout_err_o` is set, `adc_pdrst_n_o` is driven low again for `RESET_CYC` cycles, and the start-up and settling windows restart. The reset line falls for no other reason.
- R8: `timeout_err_o` stays set until the next result is delivered, and it is clear in the cycle that `result_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_pdrst_n_o | output | 1 | Converter power-down/reset, active low |
| adc_sclk_o | output | 1 | Serial clock to the converter, idles high |
| adc_data_rdy_i | input | 1 | Shared data/ready line from the converter |
| result_o | output | 16 | Last conversion result |
| status_o | output | 8 | Status bits of the last frame |
| result_valid_o | output | 1 | One-cycle strobe when result and status update |
| unsettled_o | output | 1 | Last result completed before settling ended |
| timeout_err_o | output | 1 | Ready indication missed; block is re-resetting |

## Verification
The assertions check the following on every cycle:
- the serial clock stays high and no result strobe appears while the reset line is low;
- the strobe lasts a single cycle and the outputs hold between strobes;
- the reset line falls only together with the timeout flag, and the flag is clear when a result is strobed;
- a low run of the reset line never exceeds `RESET_CYC`.

Other behaviour depends on what a converter does over time, so only the bench scenarios show it. Those scenarios cover:
- a false ready edge during start-up being ignored;
- the MSB-first bit order and the split into result and status;
- the settled/unsettled boundary after each reset;
- the exact gap from the last result to the re-reset after a timeout.

// File: rtl/sdadc_pkg.sv
// Package: shared frame geometry and sequencer state type for the host reader.
// Assumes one frame is a 16-bit result followed by 8 status bits.
package sdadc_pkg;

    localparam int FRAME_BITS  = 24;
    localparam int RESULT_BITS = 16;
    localparam int STATUS_BITS = FRAME_BITS - RESULT_BITS;

    typedef enum logic [1:0] {
        SEQ_RESET   = 2'd0,
        SEQ_POWERUP = 2'd1,
        SEQ_WAIT    = 2'd2,
        SEQ_READ    = 2'd3
    } seq_state_t;

    // Largest of three cycle counts, used to size a shared timer.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sdadc_line_sync.sv
// Module: synchroniser and falling-transition detector for the shared
// data/ready line. Assumes the line is asynchronous to clk. All stages
// reset to 1 (the idle level), so a reset never produces a false edge.
module sdadc_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o,
    output logic fall_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage capture of the line.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= line_i;
            end
        end else begin : g_chain
            // Multi-stage shift chain toward the synchronised output.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[STAGES-2:0], line_i};
            end
        end
    endgenerate

    assign line_o = sync_q[STAGES-1];

    // Holds the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= line_o;
    end

    assign fall_o = prev_q & ~line_o;

endmodule

// File: rtl/sdadc_frame_shifter.sv
// Module: serial clock generator and frame shift register. When start_i is
// seen while idle, it drives FRAME_BITS clock periods, each low for
// SCLK_HALF cycles and then high for SCLK_HALF cycles, and samples din_i in
// the last cycle of each high phase. Assumes SCLK_HALF >= 2, so that data
// launched on a falling edge crosses the synchroniser before it is sampled.
module sdadc_frame_shifter #(
    parameter int FRAME_BITS = 24,
    parameter int SCLK_HALF  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  din_i,
    output logic                  sclk_o,
    output logic                  done_o,
    output logic [FRAME_BITS-1:0] frame_o
);

    localparam int DIV_W = $clog2(SCLK_HALF + 1);
    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCLK_HALF - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

    logic                  busy_q;
    logic                  sclk_q;
    logic [DIV_W-1:0]      div_q;
    logic [BIT_W-1:0]      bit_q;
    logic [FRAME_BITS-1:0] shreg_q;
    logic                  phase_end;

    assign phase_end = (div_q == DIV_LAST);
    assign done_o    = busy_q & sclk_q & phase_end & (bit_q == BIT_LAST);
    assign frame_o   = {shreg_q[FRAME_BITS-2:0], din_i};
    assign sclk_o    = sclk_q;

    // Phase counter, serial clock level, bit counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            sclk_q  <= 1'b1;
            div_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
            div_q  <= '0;
            bit_q  <= '0;
        end else if (busy_q) begin
            if (phase_end) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                end else begin
                    shreg_q <= {shreg_q[FRAME_BITS-2:0], din_i};
                    if (bit_q == BIT_LAST) begin
                        busy_q <= 1'b0;
                    end else begin
                        bit_q  <= bit_q + 1'b1;
                        sclk_q <= 1'b0;
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdadc_pwr_sequencer.sv
// Module: reset pulse, start-up wait, ready wait with timeout, and the
// settling timer. A single timer is shared by the reset, start-up and
// timeout intervals. A separate saturating counter measures time since the
// reset line last rose. Assumes every interval parameter is at least 1.
module sdadc_pwr_sequencer
    import sdadc_pkg::*;
#(
    parameter int RESET_CYC   = 16,
    parameter int PWRUP_CYC   = 100000,
    parameter int SETTLE_CYC  = 2400000,
    parameter int TIMEOUT_CYC = 1600000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_fall_i,
    input  logic frame_done_i,
    output logic read_start_o,
    output logic pdrst_n_o,
    output logic settled_o,
    output logic timeout_o
);

    localparam int TMR_MAX = max3(RESET_CYC, PWRUP_CYC, TIMEOUT_CYC);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int SET_W   = $clog2(SETTLE_CYC + 1);
    localparam logic [TMR_W-1:0] RESET_LAST   = TMR_W'(RESET_CYC - 1);
    localparam logic [TMR_W-1:0] PWRUP_LAST   = TMR_W'(PWRUP_CYC - 1);
    localparam logic [TMR_W-1:0] TIMEOUT_LAST = TMR_W'(TIMEOUT_CYC - 1);
    localparam logic [SET_W-1:0] SETTLE_FULL  = SET_W'(SETTLE_CYC);

    seq_state_t       state_q, state_d;
    logic [TMR_W-1:0] tmr_q, tmr_d;
    logic [SET_W-1:0] settle_q;

    // Next-state and timer logic for the reset / start-up / wait / read sequence.
    always_comb begin
        state_d      = state_q;
        tmr_d        = tmr_q + 1'b1;
        read_start_o = 1'b0;
        timeout_o    = 1'b0;
        case (state_q)
            SEQ_RESET: begin
                if (tmr_q == RESET_LAST) begin
                    state_d = SEQ_POWERUP;
                    tmr_d   = '0;
                end
            end
            SEQ_POWERUP: begin
                if (tmr_q == PWRUP_LAST) begin
                    state_d = SEQ_WAIT;
                    tmr_d   = '0;
                end
            end
            SEQ_WAIT: begin
                if (ready_fall_i) begin
                    state_d      = SEQ_READ;
                    read_start_o = 1'b1;
                    tmr_d        = '0;
                end else if (tmr_q == TIMEOUT_LAST) begin
                    state_d   = SEQ_RESET;
                    timeout_o = 1'b1;
                    tmr_d     = '0;
                end
            end
            default: begin
                tmr_d = tmr_q;
                if (frame_done_i) begin
                    state_d = SEQ_WAIT;
                    tmr_d   = '0;
                end
            end
        endcase
    end

    // State and shared timer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_RESET;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    // Saturating count of cycles since the reset line was released.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == SEQ_RESET) settle_q <= '0;
        else if (settle_q != SETTLE_FULL)   settle_q <= settle_q + 1'b1;
    end

    assign pdrst_n_o = (state_q != SEQ_RESET);
    assign settled_o = (settle_q == SETTLE_FULL);

endmodule

// File: rtl/sdadc_host_reader.sv
// Module: top of the host reader. Joins the line synchroniser, the power
// sequencer and the frame shifter, and registers the parallel result,
// status, unsettled tag, valid strobe and sticky timeout flag. Assumes the
// converter returns its line high after a frame, before the next ready.
module sdadc_host_reader
    import sdadc_pkg::*;
#(
    parameter int RESET_CYC   = 16,
    parameter int PWRUP_CYC   = 100000,
    parameter int SETTLE_CYC  = 2400000,
    parameter int TIMEOUT_CYC = 1600000,
    parameter int SCLK_HALF   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic                   adc_pdrst_n_o,
    output logic                   adc_sclk_o,
    input  logic                   adc_data_rdy_i,
    output logic [RESULT_BITS-1:0] result_o,
    output logic [STATUS_BITS-1:0] status_o,
    output logic                   result_valid_o,
    output logic                   unsettled_o,
    output logic                   timeout_err_o
);

    logic                  line_s, line_fall;
    logic                  read_start, frame_done, settled, timeout_hit;
    logic [FRAME_BITS-1:0] frame_word;

    sdadc_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (adc_data_rdy_i),
        .line_o (line_s),
        .fall_o (line_fall)
    );

    sdadc_pwr_sequencer #(
        .RESET_CYC   (RESET_CYC),
        .PWRUP_CYC   (PWRUP_CYC),
        .SETTLE_CYC  (SETTLE_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ready_fall_i (line_fall),
        .frame_done_i (frame_done),
        .read_start_o (read_start),
        .pdrst_n_o    (adc_pdrst_n_o),
        .settled_o    (settled),
        .timeout_o    (timeout_hit)
    );

    sdadc_frame_shifter #(
        .FRAME_BITS (FRAME_BITS),
        .SCLK_HALF  (SCLK_HALF)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (read_start),
        .din_i   (line_s),
        .sclk_o  (adc_sclk_o),
        .done_o  (frame_done),
        .frame_o (frame_word)
    );

    // Output registers: result, status and tag update together with the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o       <= '0;
            status_o       <= '0;
            unsettled_o    <= 1'b0;
            result_valid_o <= 1'b0;
        end else begin
            result_valid_o <= frame_done;
            if (frame_done) begin
                result_o    <= frame_word[FRAME_BITS-1:STATUS_BITS];
                status_o    <= frame_word[STATUS_BITS-1:0];
                unsettled_o <= ~settled;
            end
        end
    end

    // Sticky timeout flag, cleared when the next frame completes.
    always_ff @(posedge clk) begin
        if (!rst_n)           timeout_err_o <= 1'b0;
        else if (timeout_hit) timeout_err_o <= 1'b1;
        else if (frame_done)  timeout_err_o <= 1'b0;
    end

endmodule

// File: rtl/sdadc_host_reader_chk.sv
// Module: property checker for the host reader, bound to the top module.
// Observes only the top-level ports.
module sdadc_host_reader_chk #(
    parameter int RESET_CYC = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        pdrst_n,
    input logic        sclk,
    input logic        valid,
    input logic [15:0] result,
    input logic [7:0]  status,
    input logic        unsettled,
    input logic        err
);

    int low_run;

    // Length of the current low run of the reset line.
    always_ff @(posedge clk) begin
        if (!rst_n)        low_run <= 0;
        else if (!pdrst_n) low_run <= low_run + 1;
        else               low_run <= 0;
    end

    // R2
    sclk_idle_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pdrst_n |-> sclk);

    // R2
    no_valid_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> pdrst_n);

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ($stable(result) && $stable(status) && $stable(unsettled)));

    // R7
    reset_only_on_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pdrst_n) |-> err);

    // R1
    reset_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= RESET_CYC);

    // R8
    err_clear_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !err);

endmodule

bind sdadc_host_reader sdadc_host_reader_chk #(
    .RESET_CYC (RESET_CYC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pdrst_n   (adc_pdrst_n_o),
    .sclk      (adc_sclk_o),
    .valid     (result_valid_o),
    .result    (result_o),
    .status    (status_o),
    .unsettled (unsettled_o),
    .err       (timeout_err_o)
);

// File: tb/sdadc_host_reader_tb_top.sv
// Bench: behavioural converter model plus a reference model compared on every clock.
module sdadc_host_reader_tb_top;

    localparam int RESET_CYC   = 8;
    localparam int PWRUP_CYC   = 50;
    localparam int SETTLE_CYC  = 1000;
    localparam int TIMEOUT_CYC = 800;
    localparam int SCLK_HALF   = 2;
    localparam int CONV        = 400;
    localparam int DEV_START   = 60;
    localparam int GLITCH_T    = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line = 1'b1;
    logic        pdrst_n, sclk, valid, unsettled, err;
    logic [15:0] result;
    logic [7:0]  status;

    always #5 clk = ~clk;

    sdadc_host_reader #(
        .RESET_CYC   (RESET_CYC),
        .PWRUP_CYC   (PWRUP_CYC),
        .SETTLE_CYC  (SETTLE_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .SCLK_HALF   (SCLK_HALF),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .adc_pdrst_n_o  (pdrst_n),
        .adc_sclk_o     (sclk),
        .adc_data_rdy_i (line),
        .result_o       (result),
        .status_o       (status),
        .result_valid_o (valid),
        .unsettled_o    (unsettled),
        .timeout_err_o  (err)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    longint cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [23:0] frame_word(input int k);
        logic [15:0] d;
        case (k % 6)
            0: d = 16'h0000;
            1: d = 16'hFFFF;
            2: d = 16'hA5C3;
            3: d = 16'h8001;
            4: d = 16'h7FFE;
            default: d = 16'(k * 4099 + 17);
        endcase
        return {d, 8'(k * 37 + 5)};
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- converter model ----------------
    logic [24:0] exp_q[$];
    bit          mute = 0;
    bit          tog = 0;
    int          dev_t = 0, dev_bit = 0, dev_tail = 0, fidx = 0;
    bit          dev_busy = 0;
    logic [23:0] dev_word;
    logic        dev_sclk_prev = 1'b1;

    always @(negedge clk) begin
        if (!pdrst_n) begin
            dev_t = 0; dev_busy = 0;
            tog = ~tog;
            line = tog;               // toggles during reset; must be ignored (R2)
        end else begin
            dev_t++;
            if (dev_busy) begin
                if (dev_sclk_prev && !sclk) begin
                    if (dev_bit < 24) line = dev_word[23 - dev_bit];
                    dev_bit++;
                end
                if (dev_bit >= 24) begin
                    dev_tail++;
                    if (dev_tail == 20) begin line = 1'b1; dev_busy = 0; end
                end
            end else if (!mute && dev_t >= DEV_START && (dev_t - DEV_START) % CONV == 0) begin
                dev_word = frame_word(fidx);
                exp_q.push_back({(dev_t + 100 < SETTLE_CYC), dev_word});
                fidx++;
                dev_busy = 1; dev_bit = 0; dev_tail = 0;
                line = 1'b0;
            end else if (dev_t >= GLITCH_T && dev_t < GLITCH_T + 3) begin
                line = 1'b0;              // false ready during start-up (R2)
            end else begin
                line = 1'b1;
            end
        end
        dev_sclk_prev = sclk;
    end

    // ---------------- reference model / monitor ----------------
    int          low_cnt = 0, since_rise = 0, lo_w = 0, hi_w = 0, nfalls = 0, nvalid = 0;
    bit          first_fall_pending = 0, m_sclk_prev = 1, m_valid_prev = 0;
    logic [15:0] hold_r = '0;
    logic [7:0]  hold_s = '0;
    logic        hold_u = 1'b0;
    longint      last_valid_cyc = 0;
    logic [24:0] e;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(pdrst_n || sclk, "R2", "sclk low while reset low", sclk, 1);
            if (!pdrst_n) chk(!valid, "R2", "valid while reset low", valid, 0);
            if (!pdrst_n) begin
                low_cnt++;
            end else begin
                if (low_cnt != 0) begin
                    chk(low_cnt == RESET_CYC, "R1", "reset pulse width", low_cnt, RESET_CYC);
                    since_rise = 0; first_fall_pending = 1; low_cnt = 0;
                end
                since_rise++;
            end
            if (!sclk) begin
                if (m_sclk_prev) begin
                    if (first_fall_pending)
                        chk(since_rise >= PWRUP_CYC && since_rise <= DEV_START + 8, "R2",
                            "first sclk fall after release", since_rise, DEV_START);
                    first_fall_pending = 0;
                    if (nfalls > 0) chk(hi_w == SCLK_HALF, "R3", "sclk high width", hi_w, SCLK_HALF);
                    nfalls++;
                    lo_w = 1;
                end else lo_w++;
            end else begin
                if (!m_sclk_prev) begin
                    chk(lo_w == SCLK_HALF, "R3", "sclk low width", lo_w, SCLK_HALF);
                    hi_w = 1;
                end else hi_w++;
            end
            if (m_valid_prev) chk(!valid, "R5", "valid longer than one cycle", valid, 0);
            if (valid) begin
                chk(nfalls == 24, "R3", "sclk falls per frame", nfalls, 24);
                nfalls = 0;
                if (exp_q.size() == 0) begin
                    chk(0, "R4", "unexpected result", result, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(result == e[23:8], "R4", "result", result, e[23:8]);
                    chk(status == e[7:0], "R4", "status", status, e[7:0]);
                    chk(unsettled == e[24], "R6", "unsettled tag", unsettled, e[24]);
                end
                chk(!err, "R8", "error flag at valid", err, 0);
                hold_r = result; hold_s = status; hold_u = unsettled;
                nvalid++;
                last_valid_cyc = cyc;
            end else begin
                chk(result == hold_r && status == hold_s && unsettled == hold_u, "R5",
                    "outputs changed without valid", {result, status}, {hold_r, hold_s});
            end
            m_valid_prev = valid;
            m_sclk_prev = sclk;
        end
    end

    // ---------------- scenario ----------------
    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(pdrst_n == 0, "R1", "reset line in reset", pdrst_n, 0);
        chk(sclk == 1, "R1", "sclk in reset", sclk, 1);
        chk(valid == 0, "R1", "valid in reset", valid, 0);
        chk(err == 0, "R1", "error in reset", err, 0);
        chk(result == 0, "R1", "result in reset", result, 0);
        @(posedge clk);
        rst_n <= 1'b1;

        while (nvalid < 6) @(negedge clk);
        // R7: silence the converter and expect a timeout re-reset
        mute = 1;
        do @(negedge clk); while (pdrst_n !== 1'b0);
        chk(err == 1, "R7", "error flag at re-reset", err, 1);
        chk(cyc - last_valid_cyc == TIMEOUT_CYC, "R7", "timeout gap",
            cyc - last_valid_cyc, TIMEOUT_CYC);
        mute = 0;
        repeat (RESET_CYC + 5) @(negedge clk);
        chk(err == 1, "R8", "error flag held", err, 1);

        while (nvalid < 10) @(negedge clk);
        chk(err == 0, "R8", "error flag after recovery", err, 0);
        repeat (5) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

endmodule